// File: doc/BRIEF.md
# Windowed Trigger Supervisor with Weighted Error Score

This block checks that a processor services it inside a permitted time slot of each supervision period. Every period begins with a closed slot of a configured number of cycles, followed by an open slot of a configured number of cycles. The processor services the block through a dedicated trigger pin or through a one-cycle write strobe from its register logic. A service in the open slot counts as good. A service in the closed slot counts as bad. A period whose open slot ends with no service also counts as bad. Every good or bad outcome starts a new period at the beginning of the closed slot.

The block does not fail on the first bad outcome. It keeps a saturating error score. A bad outcome adds two to the score and a good outcome subtracts one. A fault request goes high while the score is above a configured threshold, and the system uses it to enter its interrupt or safe state. Each bad outcome also produces a one-cycle interrupt pulse. An enable input turns supervision on and off, and the supervisor can run alongside other watchdogs without any dependence on them.

Top module: `trig_window_guard`

## Requirements
- R1: A service comes from a rising edge of `trig_pin` or from `trig_wr`. The pin passes through two synchroniser flops, so a rise that is set up before clock edge a is evaluated at edge a+2. A pin edge and a strobe in the same cycle count as one service.
- R2: Edges are counted from the restart edge, which is edge 0. With closed length C, a service evaluated at edges 1 through C is bad. A length of 0 behaves as 1.
- R3: With open length O, a service evaluated at edges C+1 through C+O is good. If there is no service, edge C+O is a timeout and counts as bad.
- R4: Every good or bad outcome restarts the period in the closed slot. `in_open` is 1 exactly during the open slot, starting from edge C.
- R5: A bad outcome adds 2 to `err_count`, saturating at 2^ERR_W-1. `bad_pulse` is high for one cycle after the edge that evaluated the outcome.
- R6: A good outcome subtracts 1 from `err_count`, saturating at 0. `good_pulse` is high for one cycle after the evaluating edge.
- R7: `fault_req` is 1 exactly when `err_count` is greater than `cfg_threshold`. It updates on the same edge as the count.
- R8: While `cfg_enable` is 0, no outcome occurs, `err_count` is held and the period stays at its restart point. When supervision is re-enabled, edge counting starts again from 0.
- R9: After reset, `err_count`, `fault_req`, `good_pulse`, `bad_pulse` and `in_open` are all 0, and the period starts in the closed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Turns supervision on |
| cfg_closed_len | input | LEN_W | Closed slot length in cycles |
| cfg_open_len | input | LEN_W | Open slot length in cycles |
| cfg_threshold | input | ERR_W | Score above which a fault is requested |
| trig_pin | input | 1 | Asynchronous service pin; its rising edge counts |
| trig_wr | input | 1 | One-cycle service strobe from register logic |
| good_pulse | output | 1 | One-cycle pulse on a good outcome |
| bad_pulse | output | 1 | One-cycle interrupt pulse on a bad outcome |
| err_count | output | ERR_W | Current error score |
| fault_req | output | 1 | Request to enter the interrupt or safe state |
| in_open | output | 1 | High while the open slot is running |

## Verification
Strobe services are placed on the first and last edges of the closed slot and on the last edge of the open slot, which checks both window boundaries to the exact cycle. Timeouts are checked separately from early services, because both produce the same bad pulse but arise from different conditions. Pin services are placed in both slots to check the synchroniser latency. A pin edge and a strobe in the same cycle must change the score by one step, not two. A run of timeouts drives the score to its upper limit, and a good service at a score of zero checks the lower limit. A disabled interval filled with strobes must leave the score and the pulses unchanged.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic {PH_CLOSED = 1'b0, PH_OPEN = 1'b1} phase_e;
endpackage

// File: rtl/trig_front.sv
module trig_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic wr,
  output logic trig
);
  logic [SYNC_STAGES:0] chain;
  logic                 rise;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], pin};
  end

  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  // A pin edge and a strobe together form a single service (R1)
  assign trig = rise | wr;
endmodule

// File: rtl/window_timer.sv
module window_timer
  import wwd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             trig,
  input  logic [LEN_W-1:0] closed_len,
  input  logic [LEN_W-1:0] open_len,
  output logic             good_ev,
  output logic             bad_ev,
  output logic             open_now
);
  localparam int EW = LEN_W + 1;

  phase_e           phase;
  logic [LEN_W-1:0] cnt;
  logic [EW-1:0]    cnt_inc;
  logic             closed_end, open_end;

  assign cnt_inc    = {1'b0, cnt} + EW'(1);
  assign closed_end = cnt_inc >= {1'b0, closed_len};
  assign open_end   = cnt_inc >= {1'b0, open_len};

  always_comb begin
    good_ev = en & trig & (phase == PH_OPEN);
    bad_ev  = en & ((trig & (phase == PH_CLOSED)) |
                    (~trig & (phase == PH_OPEN) & open_end));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= PH_CLOSED;
      cnt   <= '0;
    end else if (good_ev || bad_ev) begin
      phase <= PH_CLOSED;
      cnt   <= '0;
    end else if (phase == PH_CLOSED && closed_end) begin
      phase <= PH_OPEN;
      cnt   <= '0;
    end else begin
      cnt   <= cnt_inc[LEN_W-1:0];
    end
  end

  assign open_now = (phase == PH_OPEN);

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (good_ev || bad_ev) |=> (phase == PH_CLOSED && cnt == '0));

  // R3
  open_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPEN && open_len != '0) |-> (cnt < open_len));

  // R2
  closed_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (en && trig && phase == PH_CLOSED) |-> (bad_ev && !good_ev));
endmodule

// File: rtl/err_score.sv
module err_score #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             good_ev,
  input  logic             bad_ev,
  input  logic [ERR_W-1:0] threshold,
  output logic [ERR_W-1:0] score,
  output logic             fault,
  output logic             good_p,
  output logic             bad_p
);
  localparam logic [ERR_W-1:0] MAXV = {ERR_W{1'b1}};

  logic [ERR_W-1:0] nxt;

  always_comb begin
    nxt = score;
    if (bad_ev)       nxt = (score >= MAXV - ERR_W'(1)) ? MAXV : score + ERR_W'(2);
    else if (good_ev) nxt = (score == '0) ? '0 : score - ERR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score  <= '0;
      fault  <= 1'b0;
      good_p <= 1'b0;
      bad_p  <= 1'b0;
    end else begin
      score  <= nxt;
      fault  <= nxt > threshold;
      good_p <= good_ev;
      bad_p  <= bad_ev;
    end
  end

  // R5
  bad_up_chk: assert property (@(posedge clk) disable iff (rst)
    bad_ev |=> (score > $past(score) || score == MAXV));

  // R6
  good_down_chk: assert property (@(posedge clk) disable iff (rst)
    good_ev |=> (score < $past(score) || score == '0));

  // R5 R6
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({good_p, bad_p}));
endmodule

// File: rtl/trig_window_guard.sv
module trig_window_guard #(
  parameter int LEN_W       = 16,
  parameter int ERR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic [LEN_W-1:0] cfg_closed_len,
  input  logic [LEN_W-1:0] cfg_open_len,
  input  logic [ERR_W-1:0] cfg_threshold,
  input  logic             trig_pin,
  input  logic             trig_wr,
  output logic             good_pulse,
  output logic             bad_pulse,
  output logic [ERR_W-1:0] err_count,
  output logic             fault_req,
  output logic             in_open
);
  logic trig, good_ev, bad_ev;

  trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .pin(trig_pin), .wr(trig_wr), .trig(trig)
  );

  window_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .en(cfg_enable), .trig(trig),
    .closed_len(cfg_closed_len), .open_len(cfg_open_len),
    .good_ev(good_ev), .bad_ev(bad_ev), .open_now(in_open)
  );

  err_score #(.ERR_W(ERR_W)) u_score (
    .clk(clk), .rst(rst), .good_ev(good_ev), .bad_ev(bad_ev),
    .threshold(cfg_threshold), .score(err_count), .fault(fault_req),
    .good_p(good_pulse), .bad_p(bad_pulse)
  );

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && !$past(rst)) |=> $stable(err_count));
endmodule

// File: tb/trig_window_guard_test.sv
module trig_window_guard_test;
  localparam int LEN_W = 16;
  localparam int ERR_W = 4;
  localparam int C = 4;
  localparam int O = 4;
  localparam int T = 5;
  localparam int MAXV = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b1;
  logic trig_pin = 1'b0;
  logic trig_wr = 1'b0;
  logic good_pulse, bad_pulse, fault_req, in_open;
  logic [ERR_W-1:0] err_count;

  always #2 clk = ~clk;

  trig_window_guard #(.LEN_W(LEN_W), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
    .cfg_closed_len(LEN_W'(C)), .cfg_open_len(LEN_W'(O)),
    .cfg_threshold(ERR_W'(T)), .trig_pin(trig_pin), .trig_wr(trig_wr),
    .good_pulse(good_pulse), .bad_pulse(bad_pulse), .err_count(err_count),
    .fault_req(fault_req), .in_open(in_open)
  );

  typedef struct packed { logic good; logic [ERR_W-1:0] cnt; logic flt; } item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int model = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input bit good);
    item_t it;
    if (good) model = (model == 0) ? 0 : model - 1;
    else      model = (model + 2 > MAXV) ? MAXV : model + 2;
    it.good = good; it.cnt = ERR_W'(model); it.flt = (model > T);
    exp_q.push_back(it);
  endtask

  // monitor: compares every outcome pulse with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (good_pulse || bad_pulse)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected pulse", int'(err_count), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.good) check(good_pulse && !bad_pulse, "R6 good pulse", int'(bad_pulse), 0);
        else         check(bad_pulse && !good_pulse, "R5 bad pulse", int'(good_pulse), 0);
        check(err_count == it.cnt, it.good ? "R6 count" : "R5 count", int'(err_count), int'(it.cnt));
        check(fault_req == it.flt, "R7 fault", int'(fault_req), int'(it.flt));
      end
    end
  end

  task automatic do_wr(input int k, input bit good);
    push_exp(good);
    repeat (k - 1) @(negedge clk);
    trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
  endtask

  task automatic do_pin(input int k, input bit good, input bit with_wr);
    push_exp(good);
    repeat (k - 3) @(negedge clk);
    trig_pin = 1'b1;
    repeat (2) @(negedge clk);
    if (with_wr) trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
    trig_pin = 1'b0;
  endtask

  task automatic do_timeout();
    push_exp(1'b0);
    repeat (C + O) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check(err_count == 0, "R9 count", int'(err_count), 0);
    check(fault_req == 0, "R9 fault", int'(fault_req), 0);
    check(!good_pulse && !bad_pulse, "R9 pulses", int'({good_pulse, bad_pulse}), 0);
    check(in_open == 0, "R9 phase", int'(in_open), 0);
    rst = 1'b0;
    do_wr(C + 1, 1'b1);       // R6 floor at zero, R3 first open edge
    do_wr(1, 1'b0);           // R2 first closed edge
    do_wr(C, 1'b0);           // R2 last closed edge
    do_wr(C + O, 1'b1);       // R3 last open edge
    do_timeout();             // R3 timeout
    do_pin(C + 2, 1'b1, 1'b0);// R1 pin service in open slot
    do_pin(C, 1'b0, 1'b0);    // R1 pin service in closed slot, R7 fault rises
    do_pin(C + 1, 1'b1, 1'b1);// R1 pin plus strobe counted once
    check(in_open == 0, "R4 closed after restart", int'(in_open), 0);
    repeat (C) @(negedge clk);
    check(in_open == 1, "R4 open after C edges", int'(in_open), 1);
    do_wr(O, 1'b1);
    // R8 disabled: strobes ignored, score held
    cfg_enable = 1'b0;
    repeat (3) begin
      trig_wr = 1'b1; @(negedge clk);
      trig_wr = 1'b0; repeat (C + O) @(negedge clk);
    end
    check(err_count == ERR_W'(model), "R8 held count", int'(err_count), model);
    check(in_open == 0, "R8 held phase", int'(in_open), 0);
    cfg_enable = 1'b1;
    for (int i = 0; i < 6; i++) do_timeout(); // R5 saturation at top
    check(err_count == ERR_W'(MAXV), "R5 saturate", int'(err_count), MAXV);
    do_wr(C + 1, 1'b1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 outcomes seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule